// File: doc/BRIEF.md
# Half-Word Register Access Adapter

This block lets a requester with a 16-bit data path reach a bank of 32-bit registers. Every 32-bit register occupies two half-word slots, and address bit 1 picks the slot. A 32-bit write is built from two half-word writes. The lower half is parked inside the adapter. The upper half then triggers a single full-width write to the register bank.

Reads run the other way round. A lower-half read fetches the whole 32-bit word from the bank. It answers with the low 16 bits and keeps the high 16 bits in a snapshot register. A following upper-half read is answered from that snapshot without touching the bank. Software therefore sees one coherent 32-bit value even if the register changes between the two half accesses.

The register bank side is expected to return read data one cycle after the read strobe, in the manner of a synchronous RAM. Each read request gets a response pulse exactly three cycles after it is sampled, whichever half it targets.

Top module: `hw_reg_bridge`

## Requirements
- R1: Address bit 1 of a request selects the half: 0 addresses bits 15:0 of the 32-bit word, 1 addresses bits 31:16.
- R2: A write to the lower half only updates the internal 16-bit hold register; no register-side write strobe follows it.
- R3: A write to the upper half gives exactly one register-side write in the next cycle. Its data is {request data, held lower half} and its address is the request address with bits 1:0 cleared.
- R4: A read of the lower half gives exactly one register-side read strobe in the next cycle, at the request address with bits 1:0 cleared.
- R5: The response to a lower-half read carries bits 15:0 of the fetched word, with the response valid pulse three cycles after the request is sampled.
- R6: A read of the upper half issues no register-side read. It is answered, three cycles after the request, with bits 31:16 captured by the most recent lower-half read.
- R7: A register that changes between the lower-half read and the upper-half read is still returned consistently: the upper half comes from the earlier snapshot.
- R8: After reset all outputs are zero and the hold and snapshot registers read as zero. An upper-half write straight after reset stores 0 in bits 15:0, and an upper-half read returns 0.
- R9: The hold register keeps its value across any number of upper-half writes, and the snapshot keeps its value across any number of upper-half reads, until the next lower-half access of the same kind.
- R10: The register-side read and write strobes are one cycle per access and are never high together.
- R11: When a write and a read request arrive in the same cycle, the write is served and the read is dropped, with no register-side read and no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hreq_wr | input | 1 | Half-word write request, one cycle |
| hreq_rd | input | 1 | Half-word read request, one cycle |
| hreq_addr | input | AW | Byte address of the half-word; bit 1 selects the half |
| hreq_wdata | input | HW | Half-word write data |
| hrsp_valid | output | 1 | Read response pulse |
| hrsp_rdata | output | HW | Read response data |
| reg_addr | output | AW | Register-side word address, bits 1:0 zero |
| reg_wr | output | 1 | Register-side write strobe |
| reg_wdata | output | 2*HW | Register-side write data |
| reg_rd | output | 1 | Register-side read strobe |
| reg_rdata | input | 2*HW | Register-side read data, valid one cycle after reg_rd |

## Verification
A corrupted hold register does not show at the ports when it goes wrong. It appears only at the next upper-half write, in bits 15:0 of reg_wdata one cycle after that request. A corrupted snapshot shows in the response to the next upper-half read, three cycles after it. A wrong response pipeline shows at once as a missing, extra or misplaced hrsp_valid pulse relative to the request order. That is why the tests pair every lower access with delayed, repeated and out-of-step upper accesses, and change bank contents between the two halves.

// File: rtl/hwb_pkg.sv
package hwb_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_WR_LO = 3'd1,
    OP_WR_HI = 3'd2,
    OP_RD_LO = 3'd3,
    OP_RD_HI = 3'd4
  } hwb_op_e;

  // Write wins over read when both are requested together (R11).
  function automatic hwb_op_e hwb_classify(input logic wr, input logic rd,
                                           input logic upper);
    hwb_op_e op;
    if (wr)      op = upper ? OP_WR_HI : OP_WR_LO;
    else if (rd) op = upper ? OP_RD_HI : OP_RD_LO;
    else         op = OP_NONE;
    return op;
  endfunction

endpackage

// File: rtl/hwb_wr_merge.sv
module hwb_wr_merge
  import hwb_pkg::*;
#(
  parameter int HW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  hwb_op_e         op,
  input  logic [HW-1:0]   wdata,
  output logic            commit_o,
  output logic [2*HW-1:0] merged_o
);

  localparam int RW = 2 * HW;

  logic [HW-1:0] hold_q;
  logic          commit_q;
  logic [RW-1:0] merged_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= '0;
      commit_q <= 1'b0;
      merged_q <= '0;
    end else begin
      commit_q <= (op == OP_WR_HI);
      if (op == OP_WR_LO) hold_q <= wdata;
      if (op == OP_WR_HI) merged_q <= {wdata, hold_q};
    end
  end

  assign commit_o = commit_q;
  assign merged_o = merged_q;

  // R2
  lo_write_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_WR_LO) |=> !commit_q);

  // R3
  hi_write_commits_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_WR_HI) |=> commit_q && merged_q[RW-1:HW] == $past(wdata));

  // R9
  hold_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (op != OP_WR_LO) |=> $stable(hold_q));

endmodule

// File: rtl/hwb_rd_split.sv
module hwb_rd_split
  import hwb_pkg::*;
#(
  parameter int HW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  hwb_op_e         op,
  input  logic [2*HW-1:0] bank_rdata,
  output logic            fetch_o,
  output logic            rsp_valid_o,
  output logic [HW-1:0]   rsp_data_o
);

  localparam int RW = 2 * HW;

  logic          fetch_q;
  logic          hi_p1_q;
  logic          lo_p2_q;
  logic          hi_p2_q;
  logic [HW-1:0] snap_q;
  logic          rsp_valid_q;
  logic [HW-1:0] rsp_data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_q     <= 1'b0;
      hi_p1_q     <= 1'b0;
      lo_p2_q     <= 1'b0;
      hi_p2_q     <= 1'b0;
      snap_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      fetch_q     <= (op == OP_RD_LO);
      hi_p1_q     <= (op == OP_RD_HI);
      lo_p2_q     <= fetch_q;
      hi_p2_q     <= hi_p1_q;
      rsp_valid_q <= lo_p2_q | hi_p2_q;
      if (lo_p2_q) begin
        rsp_data_q <= bank_rdata[HW-1:0];
        snap_q     <= bank_rdata[RW-1:HW];
      end else if (hi_p2_q) begin
        rsp_data_q <= snap_q;
      end
    end
  end

  assign fetch_o     = fetch_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;

  // R4
  lo_read_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_RD_LO) |=> fetch_q);

  // R6
  hi_read_nofetch_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_RD_HI) |=> !fetch_q);

  // R5
  read_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_RD_LO || op == OP_RD_HI) |-> ##3 rsp_valid_q);

  // R9
  snap_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    !lo_p2_q |=> $stable(snap_q));

endmodule

// File: rtl/hw_reg_bridge.sv
module hw_reg_bridge
  import hwb_pkg::*;
#(
  parameter int AW = 12,
  parameter int HW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hreq_wr,
  input  logic            hreq_rd,
  input  logic [AW-1:0]   hreq_addr,
  input  logic [HW-1:0]   hreq_wdata,
  output logic            hrsp_valid,
  output logic [HW-1:0]   hrsp_rdata,
  output logic [AW-1:0]   reg_addr,
  output logic            reg_wr,
  output logic [2*HW-1:0] reg_wdata,
  output logic            reg_rd,
  input  logic [2*HW-1:0] reg_rdata
);

  localparam int RW      = 2 * HW;
  localparam int SEL_BIT = 1;

  hwb_op_e       op;
  logic [AW-1:0] addr_q;

  always_comb op = hwb_classify(hreq_wr, hreq_rd, hreq_addr[SEL_BIT]);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (op == OP_WR_HI || op == OP_RD_LO) begin
      addr_q <= {hreq_addr[AW-1:SEL_BIT+1], {(SEL_BIT+1){1'b0}}};
    end
  end

  assign reg_addr = addr_q;

  hwb_wr_merge #(.HW(HW)) u_wr (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .wdata    (hreq_wdata),
    .commit_o (reg_wr),
    .merged_o (reg_wdata)
  );

  hwb_rd_split #(.HW(HW)) u_rd (
    .clk         (clk),
    .rst         (rst),
    .op          (op),
    .bank_rdata  (reg_rdata),
    .fetch_o     (reg_rd),
    .rsp_valid_o (hrsp_valid),
    .rsp_data_o  (hrsp_rdata)
  );

  // R10
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_rd));

  // R11
  write_beats_read_chk: assert property (@(posedge clk) disable iff (rst)
    (hreq_wr && hreq_rd) |=> !reg_rd);

  // R3
  commit_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (hreq_wr && hreq_addr[SEL_BIT]) |=> reg_addr[SEL_BIT:0] == '0
      && reg_addr[AW-1:SEL_BIT+1] == $past(hreq_addr[AW-1:SEL_BIT+1]));

endmodule

// File: tb/tb_hw_reg_bridge.sv
module tb_hw_reg_bridge;

  localparam int AW = 12;
  localparam int HW = 16;
  localparam int RW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          hreq_wr, hreq_rd;
  logic [AW-1:0] hreq_addr;
  logic [HW-1:0] hreq_wdata;
  logic          hrsp_valid;
  logic [HW-1:0] hrsp_rdata;
  logic [AW-1:0] reg_addr;
  logic          reg_wr, reg_rd;
  logic [RW-1:0] reg_wdata, reg_rdata;

  always #4 clk = ~clk;

  hw_reg_bridge #(.AW(AW), .HW(HW)) dut (
    .clk(clk), .rst(rst), .hreq_wr(hreq_wr), .hreq_rd(hreq_rd),
    .hreq_addr(hreq_addr), .hreq_wdata(hreq_wdata),
    .hrsp_valid(hrsp_valid), .hrsp_rdata(hrsp_rdata),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  // register bank model: 8 words, one-cycle read
  logic [RW-1:0] bank [8];
  logic [RW-1:0] bank_q;
  logic          poke_en;
  logic [2:0]    poke_idx;
  logic [RW-1:0] poke_val;
  assign reg_rdata = bank_q;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) bank[i] <= '0;
      bank_q <= '0;
    end else begin
      if (reg_wr) bank[reg_addr[4:2]] <= reg_wdata;
      if (reg_rd) bank_q <= bank[reg_addr[4:2]];
      if (poke_en) bank[poke_idx] <= poke_val;
    end
  end

  int checks = 0;
  int errors = 0;
  int n_wr = 0;
  int n_rd = 0;
  int addr_bad = 0;
  logic [HW-1:0] exp_q [$];
  string         tag_q [$];

  task automatic chk(input bit ok, input string tag,
                     input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (reg_wr) n_wr++;
      if (reg_rd) n_rd++;
      if ((reg_wr || reg_rd) && reg_addr[1:0] != 2'b00) addr_bad++;
      if (hrsp_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R11 unexpected response", {16'h0, hrsp_rdata}, 32'h0);
        end else begin
          automatic logic [HW-1:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          chk(hrsp_rdata == e, t, {16'h0, hrsp_rdata}, {16'h0, e});
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input bit wr, input bit rd, input logic [AW-1:0] a,
                       input logic [HW-1:0] d);
    hreq_wr = wr; hreq_rd = rd; hreq_addr = a; hreq_wdata = d;
    @(negedge clk);
    hreq_wr = 1'b0; hreq_rd = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [HW-1:0] e,
                    input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    issue(1'b0, 1'b1, a, '0);
  endtask

  task automatic drain();
    idle(5);
    chk(exp_q.size() == 0, "R5 missing response", exp_q.size(), 0);
  endtask

  initial begin
    int wr0, rd0;
    rst = 1'b1; hreq_wr = 0; hreq_rd = 0; hreq_addr = '0; hreq_wdata = '0;
    poke_en = 0; poke_idx = '0; poke_val = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8 reset state
    chk(!hrsp_valid && !reg_wr && !reg_rd, "R8 strobes after reset",
        {hrsp_valid, reg_wr, reg_rd}, 0);
    chk(reg_wdata == 0 && reg_addr == 0 && hrsp_rdata == 0,
        "R8 data after reset", reg_wdata, 0);

    // R8 upper read before any lower read returns zero; R6 no fetch
    rd0 = n_rd;
    rd(12'h002, 16'h0000, "R8 snapshot zero");
    drain();
    chk(n_rd == rd0, "R6 upper read no fetch", n_rd - rd0, 0);

    // R8 upper write straight after reset: low half zero; R3 R1 R10
    wr0 = n_wr;
    issue(1, 0, 12'h006, 16'hBEEF);
    idle(2);
    chk(bank[1] == 32'hBEEF_0000, "R8 hold zero after reset", bank[1], 32'hBEEF_0000);
    chk(n_wr - wr0 == 1, "R10 one write cycle", n_wr - wr0, 1);

    // R2 lower write: no bank write
    wr0 = n_wr;
    issue(1, 0, 12'h008, 16'h1234);
    idle(2);
    chk(n_wr == wr0, "R2 no write strobe", n_wr - wr0, 0);
    chk(bank[2] == 0, "R2 bank untouched", bank[2], 0);

    // R3 / R1 upper write merges
    issue(1, 0, 12'h00A, 16'hABCD);
    idle(2);
    chk(bank[2] == 32'hABCD_1234, "R3 merged word", bank[2], 32'hABCD_1234);
    chk(n_wr - wr0 == 1, "R3 single write", n_wr - wr0, 1);

    // R9 hold persists across upper writes
    issue(1, 0, 12'h00E, 16'h5555);
    idle(2);
    chk(bank[3] == 32'h5555_1234, "R9 hold reused", bank[3], 32'h5555_1234);

    // R5 R6 back-to-back halves; R4 single fetch
    rd0 = n_rd;
    rd(12'h008, 16'h1234, "R5 low half");
    rd(12'h00A, 16'hABCD, "R6 high half");
    drain();
    chk(n_rd - rd0 == 1, "R4 single fetch", n_rd - rd0, 1);
    chk(addr_bad == 0, "R4 word-aligned address", addr_bad, 0);

    // R7 snapshot consistency
    rd(12'h00C, 16'h1234, "R7 low before change");
    idle(4);
    poke_en = 1; poke_idx = 3'd3; poke_val = 32'h9999_8888;
    @(negedge clk);
    poke_en = 0;
    rd(12'h00E, 16'h5555, "R7 high from snapshot");
    drain();
    rd(12'h00C, 16'h8888, "R5 low after change");
    idle(1);
    rd(12'h00E, 16'h9999, "R6 high after change");
    rd(12'h00E, 16'h9999, "R9 snapshot persists");
    drain();

    // R11 simultaneous write and read
    rd0 = n_rd;
    issue(1, 1, 12'h012, 16'h7777);
    drain();
    chk(bank[4] == 32'h7777_1234, "R11 write served", bank[4], 32'h7777_1234);
    chk(n_rd == rd0, "R11 read dropped", n_rd - rd0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule